// File: doc/BRIEF.md
# In-Order Retirement Eligibility Tracker

This block keeps a window of instructions that are in flight, in program order, and decides in each cycle which of them may leave the window. Each instruction arrives with a 3-bit class code and a tag. On arrival, a per-entry countdown is loaded with the minimum number of cycles that the class needs before it counts as complete. An entry is complete when its countdown is zero. Retirement is strictly in order: an entry leaves only when it is complete and every older entry has already left, or leaves in the same cycle from a lower slot.

Up to `RET_W` entries (two by default) retire together in one cycle. The retiring entries are always the oldest run of complete entries. The block reports which slots retire, how many retire, and their tags. Slot 0 carries the oldest of them. New instructions are accepted one per cycle while the window has a free entry.

The retire outputs are combinational from the window state. They hold in a cycle exactly when the retirement takes place, and the entries are removed at the next clock edge.

Top module: `retire_gate`

## Requirements
- R1: During reset and in the first cycle after it, `alloc_ready` is 1, `retire_valid` is all zeros and `retire_count` is 0.
- R2: A class code sets the minimum number of cycles from acceptance to retirement. The codes are: 0 integer operate, 7; 1 conditional branch, 7; 2 integer multiply, 7; 3 overflow-trapping multiply, 13; 4 memory access, 10; 5 floating add, 11; 6 floating multiply, 11; 7 spare, 7.
- R3: An instruction never retires before any instruction accepted earlier than it.
- R4: At most `RET_W` instructions retire per cycle. `retire_valid[j]` set implies `retire_valid[j-1]` set. `retire_count` equals the number of set `retire_valid` bits.
- R5: Each instruction retires in exactly the cycle max(A+S, P, Q+1). A is the cycle in which it was accepted, S is its class latency, P is the retire cycle of the previous instruction, and Q is the retire cycle of the one before that. There is no added delay.
- R6: The window holds `DEPTH` entries (default 16). `alloc_ready` is 0 exactly when all entries are occupied. A request presented while `alloc_ready` is 0 is not accepted and is not duplicated later.
- R7: `retire_tags[TAG_W*j +: TAG_W]` carries the tag of the instruction retiring in slot j. Tags leave in acceptance order, with slot 0 the oldest.
- R8: With `alloc_valid` at 0, nothing is accepted, whatever is on `alloc_class` and `alloc_tag`. Once the window has drained, no retirement appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | An instruction is offered for acceptance |
| alloc_class | input | 3 | Class code of the offered instruction |
| alloc_tag | input | TAG_W | Tag of the offered instruction |
| alloc_ready | output | 1 | A free entry exists; the offer is taken at the edge |
| retire_valid | output | RET_W | Per-slot retirement in this cycle |
| retire_count | output | $clog2(RET_W+1) | Number of instructions retiring in this cycle |
| retire_tags | output | RET_W*TAG_W | Tags of retiring instructions, slot 0 in the low bits |

## Verification
The hardest state to reach is a full window. At most one instruction is accepted per cycle, and even the slowest class becomes complete 13 cycles after acceptance. A 16-entry window can therefore never fill from the ports. The bench builds the block with 8 entries and sends a back-to-back burst of overflow-trapping multiplies. This fills the window before the first of them is complete. The bench then holds one more request against the low `alloc_ready` and confirms from the order of the retired tags that it enters exactly once. Dual retirement is provoked by placing short classes behind one long class, so that several complete entries pile up behind a single slow one.

// File: rtl/rg_pkg.sv
// Shared definitions for the retirement tracker.
// Assumes: class codes are 3 bits wide; latencies fit the counter width given here.
package rg_pkg;

    typedef enum logic [2:0] {
        CL_IOP   = 3'd0,
        CL_BR    = 3'd1,
        CL_MUL   = 3'd2,
        CL_MULV  = 3'd3,
        CL_MEM   = 3'd4,
        CL_FADD  = 3'd5,
        CL_FMUL  = 3'd6,
        CL_SPARE = 3'd7
    } rg_class_e;

    localparam int STG_SHORT = 7;
    localparam int STG_MEM   = 10;
    localparam int STG_FP    = 11;
    localparam int STG_LONG  = 13;
    localparam int CNT_W     = $clog2(STG_LONG + 1);

endpackage

// File: rtl/rg_stage_lut.sv
// Maps a class code to its minimum acceptance-to-retire latency in cycles.
// Assumes: SW is wide enough to hold the largest latency parameter.
module rg_stage_lut
    import rg_pkg::*;
#(
    parameter int SW       = CNT_W,
    parameter int LAT_S    = STG_SHORT,
    parameter int LAT_MEM  = STG_MEM,
    parameter int LAT_FP   = STG_FP,
    parameter int LAT_LONG = STG_LONG
) (
    input  logic [2:0]    cls_i,
    output logic [SW-1:0] stage_o
);

    // Decode the class into the countdown start value (R2).
    always_comb begin
        unique case (rg_class_e'(cls_i))
            CL_IOP, CL_BR, CL_MUL, CL_SPARE: stage_o = SW'(LAT_S);
            CL_MULV:                         stage_o = SW'(LAT_LONG);
            CL_MEM:                          stage_o = SW'(LAT_MEM);
            CL_FADD, CL_FMUL:                stage_o = SW'(LAT_FP);
        endcase
    end

endmodule

// File: rtl/rg_slot.sv
// One window entry: occupancy flag, tag and a countdown that reaches zero
// when the instruction has become complete.
// Assumes: load and pop never target the same entry in the same cycle,
// and load only targets a free entry.
module rg_slot
    import rg_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int SW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SW-1:0]    load_cnt_i,
    input  logic [TAG_W-1:0] load_tag_i,
    input  logic             pop_i,
    output logic             valid_o,
    output logic             done_o,
    output logic [TAG_W-1:0] tag_o
);

    logic [SW-1:0] cnt_q;

    // Capture a new instruction, count down its latency and release it on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cnt_q   <= '0;
            tag_o   <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            cnt_q   <= load_cnt_i;
            tag_o   <= load_tag_i;
        end else begin
            if (pop_i) valid_o <= 1'b0;
            if (valid_o && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
        end
    end

    // An occupied entry whose countdown is exhausted is complete.
    assign done_o = valid_o && (cnt_q == '0);

    // R3: the selector only removes occupied, complete entries.
    a_r3_pop_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (valid_o && (cnt_q == '0)));

    // R6: the tail pointer never lands on an occupied entry.
    a_r6_load_free: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_o);

endmodule

// File: rtl/rg_pick.sv
// Retire selector: walks forward from the head and grants retirement to the
// leading run of complete entries, up to RET_W of them.
// Assumes: DEPTH is a power of two so pointer arithmetic wraps; RET_W <= DEPTH.
module rg_pick #(
    parameter int DEPTH = 16,
    parameter int RET_W = 2,
    parameter int TAG_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CW    = $clog2(RET_W + 1)
) (
    input  logic [PTR_W-1:0]       head_i,
    input  logic [DEPTH-1:0]       done_i,
    input  logic [DEPTH*TAG_W-1:0] tag_i,
    output logic [RET_W-1:0]       slot_v_o,
    output logic [RET_W*TAG_W-1:0] slot_tag_o,
    output logic [CW-1:0]          count_o,
    output logic [DEPTH-1:0]       pop_o
);

    // Grant slot j only if all entries from the head up to head+j are complete.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int j = 0; j < RET_W; j++) begin
            run         = run && done_i[head_i + PTR_W'(j)];
            slot_v_o[j] = run;
        end
    end

    // Route each slot's tag from its window position.
    for (genvar j = 0; j < RET_W; j++) begin : g_tag
        logic [PTR_W-1:0] idx;
        assign idx = head_i + PTR_W'(j);
        assign slot_tag_o[j*TAG_W +: TAG_W] = tag_i[idx*TAG_W +: TAG_W];
    end

    // Count granted slots and mark the entries they free.
    always_comb begin
        count_o = '0;
        pop_o   = '0;
        for (int j = 0; j < RET_W; j++) begin
            count_o = count_o + CW'(slot_v_o[j]);
            if (slot_v_o[j]) pop_o[head_i + PTR_W'(j)] = 1'b1;
        end
    end

endmodule

// File: rtl/retire_gate.sv
// In-order retirement eligibility tracker. Instructions enter at the tail one
// per cycle, each with a class-derived countdown; the oldest complete ones
// leave from the head, up to RET_W per cycle.
// Assumes: DEPTH is a power of two; all class latencies are at least 1 so an
// entry never retires in the cycle it is accepted.
module retire_gate
    import rg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RET_W = 2,
    parameter int TAG_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [2:0]                   alloc_class,
    input  logic [TAG_W-1:0]             alloc_tag,
    output logic                         alloc_ready,
    output logic [RET_W-1:0]             retire_valid,
    output logic [$clog2(RET_W+1)-1:0]   retire_count,
    output logic [RET_W*TAG_W-1:0]       retire_tags
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;
    localparam int CW    = $clog2(RET_W + 1);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    logic [PTR_W-1:0]       head_q, tail_q;
    logic [OCC_W-1:0]       occ_q;
    logic                   push;
    logic [CNT_W-1:0]       ld_stage;
    logic [DEPTH-1:0]       ent_valid, ent_done, ent_pop;
    logic [DEPTH*TAG_W-1:0] ent_tag;

    // Accept only while a free entry exists.
    assign alloc_ready = (occ_q != FULL);
    assign push        = alloc_valid && alloc_ready;

    rg_stage_lut #(.SW(CNT_W)) u_lut (
        .cls_i   (alloc_class),
        .stage_o (ld_stage)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        rg_slot #(.TAG_W(TAG_W), .SW(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (push && (tail_q == PTR_W'(i))),
            .load_cnt_i (ld_stage),
            .load_tag_i (alloc_tag),
            .pop_i      (ent_pop[i]),
            .valid_o    (ent_valid[i]),
            .done_o     (ent_done[i]),
            .tag_o      (ent_tag[i*TAG_W +: TAG_W])
        );
    end

    rg_pick #(.DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W)) u_pick (
        .head_i     (head_q),
        .done_i     (ent_done),
        .tag_i      (ent_tag),
        .slot_v_o   (retire_valid),
        .slot_tag_o (retire_tags),
        .count_o    (retire_count),
        .pop_o      (ent_pop)
    );

    // Advance the head by the retire count, the tail by one per acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            head_q <= head_q + PTR_W'(retire_count);
            tail_q <= tail_q + PTR_W'(push);
            occ_q  <= occ_q + OCC_W'(push) - OCC_W'(retire_count);
        end
    end

    // R1: an empty window presents no retirement.
    a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (retire_valid == '0));

    // R4: the reported count agrees with the granted slots.
    a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        retire_count == CW'($countones(retire_valid)));

    // R6: occupancy matches the number of occupied entries.
    a_r6_occ_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_valid) == int'(occ_q));

    // R6: pointer distance agrees with occupancy modulo the depth.
    a_r6_ptr_span: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(tail_q - head_q) == PTR_W'(occ_q));

    // R6: a full window does not grow in the next cycle.
    a_r6_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == FULL) |=> (occ_q <= $past(occ_q)));

endmodule

// File: tb/sim_retire_gate.sv
module sim_retire_gate;

    localparam int DEPTH = 8;
    localparam int RET_W = 2;
    localparam int TAG_W = 8;
    localparam int NV    = 24;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     alloc_valid = 1'b0;
    logic [2:0]               alloc_class = '0;
    logic [TAG_W-1:0]         alloc_tag = '0;
    logic                     alloc_ready;
    logic [RET_W-1:0]         retire_valid;
    logic [1:0]               retire_count;
    logic [RET_W*TAG_W-1:0]   retire_tags;

    retire_gate #(.DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W)) u0 (
        .clk, .rst_n, .alloc_valid, .alloc_class, .alloc_tag,
        .alloc_ready, .retire_valid, .retire_count, .retire_tags
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nal = 0;
    int rptr = 0;
    int exp_c [256];
    bit mon_on = 1'b0;
    bit ended = 1'b0;
    int seen;

    // Stimulus vectors: {gap before issue [5:3], class [2:0]}.
    localparam logic [5:0] VEC [NV] = '{
        {3'd0, 3'd0}, {3'd0, 3'd1}, {3'd2, 3'd4}, {3'd0, 3'd5},
        {3'd0, 3'd3}, {3'd0, 3'd0}, {3'd0, 3'd2}, {3'd0, 3'd1},
        {3'd0, 3'd7}, {3'd5, 3'd6}, {3'd0, 3'd4}, {3'd1, 3'd0},
        {3'd7, 3'd3}, {3'd0, 3'd4}, {3'd0, 3'd5}, {3'd0, 3'd6},
        {3'd0, 3'd0}, {3'd3, 3'd2}, {3'd0, 3'd3}, {3'd0, 3'd3},
        {3'd0, 3'd1}, {3'd0, 3'd0}, {3'd6, 3'd5}, {3'd0, 3'd7}
    };

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'd3:       return 13;
            3'd4:       return 10;
            3'd5, 3'd6: return 11;
            default:    return 7;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Retirement monitor: tags in order (R3, R7), exact cycle (R5), slot rules (R4).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            seen = 0;
            if (retire_valid[1] && !retire_valid[0])
                chk(1'b0, "R4 slot1 without slot0", int'(retire_valid), 1);
            for (int j = 0; j < RET_W; j++) begin
                if (retire_valid[j]) begin
                    seen++;
                    if (rptr >= nal) begin
                        chk(1'b0, "R8 unexpected retirement", rptr, nal);
                    end else begin
                        chk(retire_tags[j*TAG_W +: TAG_W] == rptr[TAG_W-1:0], "R7/R3 tag order",
                            int'(retire_tags[j*TAG_W +: TAG_W]), rptr);
                        chk(cyc == exp_c[rptr], "R5 retire cycle", cyc, exp_c[rptr]);
                    end
                    rptr++;
                end
            end
            if (seen != 0)
                chk(int'(retire_count) == seen, "R4 retire_count", int'(retire_count), seen);
            if (rptr < nal && exp_c[rptr] <= cyc)
                chk(1'b0, "R5 retirement late", cyc, exp_c[rptr]);
        end
    end

    // Offer one instruction; hold it until accepted, then log its expected retire cycle (R5, R2).
    task automatic issue(input logic [2:0] c);
        int k, e;
        alloc_valid = 1'b1;
        alloc_class = c;
        alloc_tag   = nal[TAG_W-1:0];
        while (!alloc_ready) @(negedge clk);
        k = cyc + 1;
        e = k + lat_of(c);
        if (nal > 0 && exp_c[nal-1] > e) e = exp_c[nal-1];
        if (nal > 1 && exp_c[nal-2] + 1 > e) e = exp_c[nal-2] + 1;
        exp_c[nal] = e;
        nal++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        alloc_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain();
        alloc_valid = 1'b0;
        for (int i = 0; i < 200 && rptr < nal; i++) @(negedge clk);
        chk(rptr == nal, "R5 drain complete", rptr, nal);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        // R1: reset state, during and right after reset.
        repeat (3) @(negedge clk);
        chk(alloc_ready == 1'b1, "R1 ready in reset", int'(alloc_ready), 1);
        chk(retire_valid == '0, "R1 no retire in reset", int'(retire_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R1 ready after reset", int'(alloc_ready), 1);
        chk(retire_count == '0, "R1 count after reset", int'(retire_count), 0);
        mon_on = 1'b1;

        // Vector walk: mixed classes and gaps (R2, R3, R5, R7).
        for (int v = 0; v < NV; v++) begin
            idle(int'(VEC[v][5:3]));
            issue(VEC[v][2:0]);
        end
        drain();

        // R2: isolated instruction of each class retires at exactly its latency.
        for (int c = 0; c < 8; c++) begin
            issue(3'(c));
            drain();
            idle(2);
        end

        // R4: one long op then short ones pile up and retire in pairs.
        issue(3'd3);
        for (int i = 0; i < 6; i++) issue(3'd0);
        drain();

        // R6: fill the window with long ops, then press one more against a low ready.
        for (int i = 0; i < DEPTH; i++) issue(3'd3);
        chk(alloc_ready == 1'b0, "R6 ready low when full", int'(alloc_ready), 0);
        issue(3'd0);
        chk(alloc_ready == 1'b1, "R6 ready back after retire", int'(alloc_ready), 1);
        drain();

        // R8: garbage on class/tag with valid low produces no acceptance or retirement.
        alloc_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            alloc_class = 3'(i);
            alloc_tag   = 8'(i * 7);
            @(negedge clk);
            chk(retire_valid == '0, "R8 idle no retire", int'(retire_valid), 0);
        end

        // R1: reset again after draining and confirm the idle state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(alloc_ready == 1'b1 && retire_valid == '0, "R1 state after second reset",
            int'(retire_valid), 0);

        finish_run();
    end

endmodule